// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block runs the full command sequence for changing the contents of a serial NOR flash. It sits above a transaction engine that moves single commands on the serial bus. The host asks for one operation: a 4 KiB sector erase, a 32 KiB or 64 KiB block erase, a whole-device erase, or a program of N bytes at a byte address. The sequencer then issues every engine transaction itself. It reads the device status until any earlier write has finished. It sends write-enable before each modifying command. After that command it reads the status again until the device is idle.

A program request may cross 256-byte page boundaries. The sequencer cuts it into chunks so that no chunk crosses a page. Each chunk runs its own write-enable, program and status-poll round. The host delivers the program bytes on a byte stream with a valid/ready handshake. That stream is connected straight through to the engine while a program transaction is in flight, and is held off at all other times.

The host sees a registered acknowledge when a request is taken. It sees a one-cycle completion pulse when the request ends, with a two-bit result code. The gap between successive status reads and the largest number of reads allowed are set on input pins.

Top module: `flash_op_seq`

## Requirements
- R1: While reset is held, and before any request, `eng_start`, `req_ack`, `op_done` and `host_byte_ready` are all 0.
- R2: An accepted request that is not rejected or empty first issues status reads. A status read has opcode 0x05 and length 1, and bit 0 of the returned byte is the busy flag. Reads repeat while that flag is 1. No other transaction starts until a read returns the flag as 0.
- R3: Every erase or program transaction is immediately preceded by a write-enable transaction. Write-enable has opcode 0x06 and length 0.
- R4: `req_kind` selects the operation: 0 is a 4 KiB erase (opcode 0x20), 1 is a 32 KiB erase (0x52), 2 is a 64 KiB erase (0xD8), 3 is a full erase (0xC7) and 4 is program. For the three region erases, the address is cut to its low 24 bits and rounded down to a multiple of the region size. A full erase uses address 0. Every erase transaction has length 0.
- R5: A program is issued as opcode 0x02 transactions. Each chunk is the smaller of the bytes remaining and 256 minus (address mod 256). After each chunk, the address advances and the remaining count drops by the chunk length, until nothing remains.
- R6: Program bytes pass from the host stream to the engine in order and unchanged, only while a program transaction is in flight. Exactly the requested number of bytes is consumed from the host.
- R7: After every erase or program transaction, status reads repeat until the busy flag is 0. After the read that ends the request, `op_done` pulses for one cycle with `op_status` = 0.
- R8: After a status read that returns busy, the next status read starts exactly `poll_gap`+1 cycles after the cycle in which `eng_done` was high.
- R9: Within one polling phase, if status read number max(`poll_limit`,1) still returns busy, the request ends. `op_done` then pulses with `op_status` = 2, and no further transaction is issued.
- R10: A request is rejected with `op_status` = 1 and no flash traffic in these cases: a program whose 32-bit address plus length exceeds 0x800000; a region erase whose aligned 24-bit address is at or above 0x800000; or any `req_kind` above 4. `op_done` then pulses in the same cycle as `req_ack`.
- R11: A program of length 0 ends with `op_done` and `op_status` = 0 in the same cycle as `req_ack`, with no flash traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_kind | input | 3 | Operation select (see R4) |
| req_addr | input | 32 | Byte address |
| req_len | input | LEN_W | Program length in bytes |
| req_ack | output | 1 | One-cycle pulse: request taken |
| poll_gap | input | GAP_W | Idle cycles between status reads |
| poll_limit | input | POLL_W | Largest number of status reads per polling phase |
| host_byte_valid | input | 1 | Program byte available |
| host_byte_data | input | 8 | Program byte |
| host_byte_ready | output | 1 | Program byte taken this cycle |
| eng_start | output | 1 | One-cycle pulse: start a transaction |
| eng_opcode | output | 8 | Opcode of the transaction |
| eng_addr | output | ADDR_W | Flash address of the transaction |
| eng_len | output | CHUNK_W | Data bytes in the transaction |
| eng_byte_valid | output | 1 | Program byte offered to the engine |
| eng_byte_data | output | 8 | Program byte to the engine |
| eng_byte_ready | input | 1 | Engine takes a program byte |
| eng_done | input | 1 | Transaction finished |
| eng_rdata | input | 8 | Byte returned by a status read, valid with `eng_done` |
| op_done | output | 1 | One-cycle pulse: request finished |
| op_status | output | 2 | Result: 0 done, 1 rejected, 2 poll timeout |

## Verification
Most wrong internal states show up at the engine port within one transaction. A stale page offset produces a chunk that crosses a page boundary or has the wrong length. It shows on the first `eng_start` of the next chunk. A lost polling-phase flag shows as write-enable issued before the device is idle, or as a request that completes too early. Either is visible at the next `eng_start` or `op_done`.

A miscounted gap or poll counter moves the start of the next status read by a measurable number of cycles. It can also move the timeout completion earlier or later by one read. A wrong byte-path gate shows on the host stream before the program command starts.

// File: rtl/flash_op_seq_pkg.sv
package flash_op_seq_pkg;

  typedef enum logic [2:0] {
    KIND_ERASE_4K  = 3'd0,
    KIND_ERASE_32K = 3'd1,
    KIND_ERASE_64K = 3'd2,
    KIND_ERASE_ALL = 3'd3,
    KIND_PROGRAM   = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_RANGE   = 2'd1,
    RES_TIMEOUT = 2'd2
  } op_result_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_POLL_ISSUE,
    SQ_POLL_WAIT,
    SQ_GAP,
    SQ_WEN_ISSUE,
    SQ_WEN_WAIT,
    SQ_CMD_ISSUE,
    SQ_CMD_WAIT
  } seq_state_e;

  localparam logic [7:0] OPC_STATUS_RD = 8'h05;
  localparam logic [7:0] OPC_WRITE_EN  = 8'h06;
  localparam logic [7:0] OPC_ERASE_4K  = 8'h20;
  localparam logic [7:0] OPC_ERASE_32K = 8'h52;
  localparam logic [7:0] OPC_ERASE_64K = 8'hD8;
  localparam logic [7:0] OPC_ERASE_ALL = 8'hC7;
  localparam logic [7:0] OPC_PAGE_PROG = 8'h02;

endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_op_seq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_W        = 16,
  parameter int FLASH_BYTES  = 8388608,
  parameter int SECTOR_BYTES = 4096,
  parameter int BLK_S_BYTES  = 32768,
  parameter int BLK_L_BYTES  = 65536
) (
  input  logic [2:0]        kind,
  input  logic [31:0]       addr,
  input  logic [LEN_W-1:0]  len,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] start_addr,
  output logic              is_prog,
  output logic              reject,
  output logic              empty
);

  localparam logic [ADDR_W-1:0] MASK_S = ~ADDR_W'(SECTOR_BYTES - 1);
  localparam logic [ADDR_W-1:0] MASK_M = ~ADDR_W'(BLK_S_BYTES - 1);
  localparam logic [ADDR_W-1:0] MASK_L = ~ADDR_W'(BLK_L_BYTES - 1);

  logic [ADDR_W-1:0] low_addr;
  logic [32:0]       prog_end;
  logic              erase_oob;

  assign low_addr = addr[ADDR_W-1:0];
  assign prog_end = {1'b0, addr} + 33'(len);

  always_comb begin
    opcode     = OPC_ERASE_ALL;
    start_addr = '0;
    is_prog    = 1'b0;
    reject     = 1'b0;
    empty      = 1'b0;
    erase_oob  = 1'b0;
    case (kind)
      KIND_ERASE_4K: begin
        opcode     = OPC_ERASE_4K;
        start_addr = low_addr & MASK_S;
        erase_oob  = 1'b1;
      end
      KIND_ERASE_32K: begin
        opcode     = OPC_ERASE_32K;
        start_addr = low_addr & MASK_M;
        erase_oob  = 1'b1;
      end
      KIND_ERASE_64K: begin
        opcode     = OPC_ERASE_64K;
        start_addr = low_addr & MASK_L;
        erase_oob  = 1'b1;
      end
      KIND_ERASE_ALL: begin
        opcode     = OPC_ERASE_ALL;
        start_addr = '0;
      end
      KIND_PROGRAM: begin
        opcode     = OPC_PAGE_PROG;
        start_addr = low_addr;
        is_prog    = 1'b1;
        reject     = (prog_end > 33'(FLASH_BYTES));
        empty      = (len == '0);
      end
      default: reject = 1'b1;
    endcase
    if (erase_oob && (32'(start_addr) >= 32'(FLASH_BYTES))) begin
      reject = 1'b1;
    end
  end

endmodule

// File: rtl/flash_page_chunk.sv
module flash_page_chunk #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_AW   = $clog2(PAGE_BYTES),
  localparam int CHUNK_W   = PAGE_AW + 1
) (
  input  logic [PAGE_AW-1:0] addr_lo,
  input  logic [LEN_W-1:0]   remaining,
  output logic [CHUNK_W-1:0] chunk
);

  logic [CHUNK_W-1:0] room;

  assign room  = CHUNK_W'(PAGE_BYTES) - CHUNK_W'(addr_lo);
  assign chunk = (remaining < LEN_W'(room)) ? CHUNK_W'(remaining) : room;

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_op_seq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 16,
  parameter int GAP_W       = 8,
  parameter int POLL_W      = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int FLASH_BYTES = 8388608,
  localparam int CHUNK_W    = $clog2(PAGE_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic [31:0]        req_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic               req_ack,
  input  logic [GAP_W-1:0]   poll_gap,
  input  logic [POLL_W-1:0]  poll_limit,
  input  logic               host_byte_valid,
  input  logic [7:0]         host_byte_data,
  output logic               host_byte_ready,
  output logic               eng_start,
  output logic [7:0]         eng_opcode,
  output logic [ADDR_W-1:0]  eng_addr,
  output logic [CHUNK_W-1:0] eng_len,
  output logic               eng_byte_valid,
  output logic [7:0]         eng_byte_data,
  input  logic               eng_byte_ready,
  input  logic               eng_done,
  input  logic [7:0]         eng_rdata,
  output logic               op_done,
  output logic [1:0]         op_status
);

  localparam int PAGE_AW = $clog2(PAGE_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // request decode and page split
  logic [7:0]         dec_op;
  logic [ADDR_W-1:0]  dec_addr;
  logic               dec_prog, dec_reject, dec_empty;
  logic [CHUNK_W-1:0] chunk;

  flash_op_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FLASH_BYTES(FLASH_BYTES)
  ) u_decode (
    .kind(req_kind), .addr(req_addr), .len(req_len),
    .opcode(dec_op), .start_addr(dec_addr), .is_prog(dec_prog),
    .reject(dec_reject), .empty(dec_empty)
  );

  seq_state_e        state_q, state_d;
  logic              post_q, post_d;
  logic              prog_q, prog_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [7:0]        cmd_q, cmd_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              ack_q, ack_d;
  logic              done_q, done_d;
  logic [1:0]        res_q, res_d;
  logic              ctx_en;
  logic              limit_hit;
  logic              rdata_unused;

  flash_page_chunk #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_chunk (
    .addr_lo(addr_q[PAGE_AW-1:0]), .remaining(rem_q), .chunk(chunk)
  );

  assign limit_hit    = ((POLL_W+1)'(polls_q) + (POLL_W+1)'(1)) >= (POLL_W+1)'(poll_limit);
  assign rdata_unused = ^eng_rdata[7:1];

  // next state
  always_comb begin
    state_d = state_q;
    post_d  = post_q;
    prog_d  = prog_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    cmd_d   = cmd_q;
    polls_d = polls_q;
    gap_d   = gap_q;
    ack_d   = 1'b0;
    done_d  = 1'b0;
    res_d   = res_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          ack_d = 1'b1;
          if (dec_reject) begin
            done_d = 1'b1;
            res_d  = RES_RANGE;
          end else if (dec_empty) begin
            done_d = 1'b1;
            res_d  = RES_OK;
          end else begin
            state_d = SQ_POLL_ISSUE;
            post_d  = 1'b0;
            prog_d  = dec_prog;
            addr_d  = dec_addr;
            rem_d   = req_len;
            cmd_d   = dec_op;
            polls_d = '0;
          end
        end
      end
      SQ_POLL_ISSUE: state_d = SQ_POLL_WAIT;
      SQ_POLL_WAIT: begin
        if (eng_done) begin
          if (!eng_rdata[0]) begin
            polls_d = '0;
            if (!post_q) begin
              state_d = SQ_WEN_ISSUE;
            end else if (prog_q && (rem_q > LEN_W'(chunk))) begin
              addr_d  = addr_q + ADDR_W'(chunk);
              rem_d   = rem_q - LEN_W'(chunk);
              state_d = SQ_WEN_ISSUE;
            end else begin
              state_d = SQ_IDLE;
              done_d  = 1'b1;
              res_d   = RES_OK;
            end
          end else if (limit_hit) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            res_d   = RES_TIMEOUT;
          end else begin
            polls_d = polls_q + 1'b1;
            gap_d   = poll_gap;
            state_d = (poll_gap == '0) ? SQ_POLL_ISSUE : SQ_GAP;
          end
        end
      end
      SQ_GAP: begin
        if (gap_q <= GAP_W'(1)) state_d = SQ_POLL_ISSUE;
        else                    gap_d   = gap_q - 1'b1;
      end
      SQ_WEN_ISSUE: state_d = SQ_WEN_WAIT;
      SQ_WEN_WAIT:  if (eng_done) state_d = SQ_CMD_ISSUE;
      SQ_CMD_ISSUE: state_d = SQ_CMD_WAIT;
      SQ_CMD_WAIT: begin
        if (eng_done) begin
          state_d = SQ_POLL_ISSUE;
          post_d  = 1'b1;
          polls_d = '0;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign ctx_en = (state_q != SQ_IDLE) || req_valid;

  // control registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= SQ_IDLE;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  // request context, updated only while a request is live
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      post_q  <= 1'b0;
      prog_q  <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      cmd_q   <= '0;
      polls_q <= '0;
      gap_q   <= '0;
    end else if (ctx_en) begin
      post_q  <= post_d;
      prog_q  <= prog_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      cmd_q   <= cmd_d;
      polls_q <= polls_d;
      gap_q   <= gap_d;
    end
  end

  // engine request port
  always_comb begin
    eng_start  = 1'b0;
    eng_opcode = '0;
    eng_addr   = '0;
    eng_len    = '0;
    case (state_q)
      SQ_POLL_ISSUE: begin
        eng_start  = 1'b1;
        eng_opcode = OPC_STATUS_RD;
        eng_len    = CHUNK_W'(1);
      end
      SQ_WEN_ISSUE: begin
        eng_start  = 1'b1;
        eng_opcode = OPC_WRITE_EN;
      end
      SQ_CMD_ISSUE: begin
        eng_start  = 1'b1;
        eng_opcode = cmd_q;
        eng_addr   = addr_q;
        eng_len    = prog_q ? chunk : '0;
      end
      default: ;
    endcase
  end

  // byte stream: connected only while a program command is running
  logic byte_gate;
  assign byte_gate       = (state_q == SQ_CMD_WAIT) && prog_q;
  assign host_byte_ready = byte_gate && eng_byte_ready;
  assign eng_byte_valid  = byte_gate && host_byte_valid;
  assign eng_byte_data   = host_byte_data;

  assign req_ack   = ack_q;
  assign op_done   = done_q;
  assign op_status = res_q;

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk
  import flash_op_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int CHUNK_W   = $clog2(PAGE_BYTES) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ack,
  input logic               op_done,
  input logic [1:0]         op_status,
  input logic               eng_start,
  input logic [7:0]         eng_opcode,
  input logic [ADDR_W-1:0]  eng_addr,
  input logic [CHUNK_W-1:0] eng_len,
  input logic               host_byte_ready
);

  localparam int PAGE_AW = $clog2(PAGE_BYTES);

  logic [7:0] last_op;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_op <= 8'h00;
    else if (eng_start) last_op <= eng_opcode;
  end

  logic is_modify;
  assign is_modify = (eng_opcode != OPC_STATUS_RD) && (eng_opcode != OPC_WRITE_EN);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_status_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_opcode == OPC_STATUS_RD) |-> (eng_len == CHUNK_W'(1)));

  p_wen_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && is_modify) |-> (last_op == OPC_WRITE_EN));

  p_erase_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |->
      ((eng_opcode != OPC_ERASE_4K  || eng_addr[11:0] == '0) &&
       (eng_opcode != OPC_ERASE_32K || eng_addr[14:0] == '0) &&
       (eng_opcode != OPC_ERASE_64K || eng_addr[15:0] == '0) &&
       (eng_opcode != OPC_ERASE_ALL || eng_addr == '0)));

  p_page_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_opcode == OPC_PAGE_PROG) |->
      (eng_len != '0 &&
       ((CHUNK_W+1)'(eng_addr[PAGE_AW-1:0]) + (CHUNK_W+1)'(eng_len)) <= (CHUNK_W+1)'(PAGE_BYTES)));

  p_bytes_in_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_byte_ready |-> (last_op == OPC_PAGE_PROG));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  p_reject_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_status == RES_RANGE) |-> req_ack);

endmodule

bind flash_op_seq flash_op_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .op_done(op_done),
  .op_status(op_status), .eng_start(eng_start), .eng_opcode(eng_opcode),
  .eng_addr(eng_addr), .eng_len(eng_len), .host_byte_ready(host_byte_ready)
);

// File: tb/flash_op_seq_bench.sv
`timescale 1ns/1ps
module flash_op_seq_bench;

  logic        clk, rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        req_ack;
  logic [7:0]  poll_gap;
  logic [15:0] poll_limit;
  logic        host_byte_valid;
  logic [7:0]  host_byte_data;
  logic        host_byte_ready;
  logic        eng_start;
  logic [7:0]  eng_opcode;
  logic [23:0] eng_addr;
  logic [8:0]  eng_len;
  logic        eng_byte_valid;
  logic [7:0]  eng_byte_data;
  logic        eng_byte_ready;
  logic        eng_done;
  logic [7:0]  eng_rdata;
  logic        op_done;
  logic [1:0]  op_status;

  flash_op_seq u_flash_op_seq (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // engine model state
  int txn_n = 0;
  logic [7:0]  t_op   [64];
  logic [23:0] t_addr [64];
  int          t_len  [64];
  int          t_start[64];
  int          t_done [64];
  int busy_left = 0, post_busy = 0;
  int got = 0, hsent = 0;
  logic [7:0] cap [1024];

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  assign host_byte_valid = 1'b1;
  assign host_byte_data  = pat(hsent);

  always @(posedge clk) begin
    if (eng_byte_valid && eng_byte_ready) begin
      cap[got % 1024] <= eng_byte_data;
      got <= got + 1;
    end
    if (host_byte_valid && host_byte_ready) hsent <= hsent + 1;
  end

  initial begin
    eng_done = 1'b0; eng_rdata = 8'h00; eng_byte_ready = 1'b0;
    @(negedge clk);
    forever begin
      if (rst_n && eng_start) begin
        int idx, target;
        logic [7:0] op;
        idx = txn_n % 64;
        op  = eng_opcode;
        t_op[idx] = op; t_addr[idx] = eng_addr; t_len[idx] = int'(eng_len);
        t_start[idx] = cyc;
        txn_n++;
        repeat (2) @(negedge clk);
        if (op == 8'h02) begin
          target = got + t_len[idx];
          eng_byte_ready = 1'b1;
          while (got < target) @(negedge clk);
          eng_byte_ready = 1'b0;
        end
        eng_rdata = 8'h00;
        if (op == 8'h05 && busy_left > 0) begin
          eng_rdata = 8'h01;
          busy_left--;
        end
        if (op == 8'h20 || op == 8'h52 || op == 8'hD8 || op == 8'hC7 || op == 8'h02)
          busy_left = post_busy;
        eng_done = 1'b1;
        t_done[idx] = cyc;
        @(negedge clk);
        eng_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected transaction list
  int exp_n;
  logic [7:0]  e_op  [64];
  logic [23:0] e_addr[64];
  int          e_len [64];

  task automatic ex_add(input logic [7:0] op, input logic [23:0] a, input int n);
    e_op[exp_n] = op; e_addr[exp_n] = a; e_len[exp_n] = n; exp_n++;
  endtask

  task automatic ex_polls(input int n);
    for (int i = 0; i < n; i++) ex_add(8'h05, 24'h0, 1);
  endtask

  task automatic ex_cmp(input string req);
    int bad;
    bad = -1;
    chk({req, " transaction count"}, txn_n == exp_n, txn_n, exp_n);
    for (int i = 0; i < exp_n && i < txn_n; i++)
      if (bad < 0 && (t_op[i] != e_op[i] || t_addr[i] != e_addr[i] || t_len[i] != e_len[i]))
        bad = i;
    if (bad >= 0)
      chk({req, " transaction op/addr/len"}, 1'b0,
          {t_op[bad], t_addr[bad], 16'(t_len[bad])}, {e_op[bad], e_addr[bad], 16'(e_len[bad])});
    else
      chk({req, " transaction list"}, 1'b1, 0, 0);
  endtask

  task automatic do_op(input logic [2:0] k, input logic [31:0] a, input int n,
                       output int st, output int ack_c, output int done_c);
    int guard;
    guard = 0; st = -1; ack_c = -1; done_c = -1;
    txn_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = 16'(n);
    do begin @(negedge clk); guard++; end while (!req_ack && guard < 5000);
    ack_c = cyc;
    req_valid = 1'b0;
    while (!op_done && guard < 40000) begin @(negedge clk); guard++; end
    if (guard >= 40000) chk("request completion", 1'b0, guard, 0);
    done_c = cyc;
    st = int'(op_status);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 eng_start in reset", eng_start == 1'b0, eng_start, 0);
    chk("R1 req_ack/op_done in reset", {req_ack, op_done} == 2'b00, {req_ack, op_done}, 0);
    chk("R1 host_byte_ready in reset", host_byte_ready == 1'b0, host_byte_ready, 0);
  endtask

  task automatic t_sector;
    int st, a, d;
    busy_left = 2; post_busy = 3; poll_gap = 0; poll_limit = 100;
    do_op(3'd0, 32'h1234_5678, 0, st, a, d);
    exp_n = 0;
    ex_polls(3); ex_add(8'h06, 0, 0); ex_add(8'h20, 24'h345000, 0); ex_polls(4);
    ex_cmp("R2 R3 R4 R7 sector erase");
    chk("R7 sector erase status", st == 0, st, 0);
  endtask

  task automatic t_erase_kinds;
    int st, a, d;
    busy_left = 0; post_busy = 0;
    do_op(3'd1, 32'h000A_BCDE, 0, st, a, d);
    chk("R4 32K erase opcode/addr", t_op[2] == 8'h52 && t_addr[2] == 24'h0A8000, {t_op[2], t_addr[2]}, 32'h520A8000);
    do_op(3'd2, 32'h007F_FFFF, 0, st, a, d);
    chk("R4 64K erase opcode/addr", t_op[2] == 8'hD8 && t_addr[2] == 24'h7F0000, {t_op[2], t_addr[2]}, 32'hD87F0000);
    do_op(3'd3, 32'h0000_0123, 0, st, a, d);
    exp_n = 0;
    ex_polls(1); ex_add(8'h06, 0, 0); ex_add(8'hC7, 0, 0); ex_polls(1);
    ex_cmp("R4 R3 full erase");
    do_op(3'd0, 32'h0100_0010, 0, st, a, d);
    chk("R4 24-bit address mask", st == 0 && t_addr[2] == 24'h0, {st, t_addr[2]}, 0);
  endtask

  task automatic t_program(input logic [31:0] a0, input int n, input string tag);
    int st, a, d, gb, hb, addr, left, bad;
    busy_left = 0; post_busy = 0;
    gb = got; hb = hsent;
    do_op(3'd4, a0, n, st, a, d);
    exp_n = 0; ex_polls(1);
    addr = int'(a0); left = n;
    while (left > 0) begin
      int c;
      c = 256 - (addr % 256);
      if (left < c) c = left;
      ex_add(8'h06, 0, 0); ex_add(8'h02, 24'(addr), c); ex_polls(1);
      addr += c; left -= c;
    end
    ex_cmp({"R5 R3 ", tag});
    chk({"R6 bytes to engine ", tag}, got - gb == n, got - gb, n);
    chk({"R6 bytes from host ", tag}, hsent - hb == n, hsent - hb, n);
    bad = -1;
    for (int i = 0; i < n; i++)
      if (bad < 0 && cap[(gb + i) % 1024] != pat(hb + i)) bad = i;
    chk({"R6 byte order/value ", tag}, bad < 0, bad, -1);
    chk({"R7 program status ", tag}, st == 0, st, 0);
  endtask

  task automatic t_gap;
    int st, a, d;
    busy_left = 1; post_busy = 0; poll_gap = 5; poll_limit = 100;
    do_op(3'd0, 32'h0, 0, st, a, d);
    chk("R8 gap of 5", t_start[1] - t_done[0] == 6, t_start[1] - t_done[0], 6);
    busy_left = 1; poll_gap = 0;
    do_op(3'd0, 32'h0, 0, st, a, d);
    chk("R8 gap of 0", t_start[1] - t_done[0] == 1, t_start[1] - t_done[0], 1);
  endtask

  task automatic t_timeout;
    int st, a, d;
    busy_left = 10; post_busy = 0; poll_gap = 1; poll_limit = 3;
    do_op(3'd2, 32'h0, 0, st, a, d);
    repeat (30) @(negedge clk);
    chk("R9 timeout status", st == 2, st, 2);
    chk("R9 reads before timeout", txn_n == 3, txn_n, 3);
    busy_left = 0; post_busy = 5; poll_limit = 4;
    do_op(3'd3, 32'h0, 0, st, a, d);
    chk("R9 timeout in post-command phase", st == 2 && txn_n == 7, {st, txn_n}, {2, 7});
    busy_left = 0; post_busy = 0; poll_gap = 0; poll_limit = 100;
  endtask

  task automatic t_range;
    int st, a, d;
    busy_left = 0; post_busy = 0;
    do_op(3'd4, 32'h007F_FF00, 257, st, a, d);
    chk("R10 program past end rejected", st == 1 && a == d && txn_n == 0, {st, txn_n}, {1, 0});
    do_op(3'd0, 32'h0080_0000, 0, st, a, d);
    chk("R10 erase past end rejected", st == 1 && a == d && txn_n == 0, {st, txn_n}, {1, 0});
    do_op(3'd6, 32'h0, 4, st, a, d);
    chk("R10 unknown kind rejected", st == 1 && txn_n == 0, {st, txn_n}, {1, 0});
    do_op(3'd4, 32'h0, 0, st, a, d);
    chk("R11 empty program", st == 0 && a == d && txn_n == 0, {st, txn_n}, {0, 0});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1'b0, cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 0; req_addr = 0; req_len = 0;
    poll_gap = 0; poll_limit = 100;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_sector;
    t_erase_kinds;
    t_program(32'h0000_00F0, 300, "cross two pages");
    t_program(32'h0000_0400, 256, "one full page");
    t_program(32'h007F_FF00, 256, "last page");
    t_gap;
    t_timeout;
    t_range;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule